// File: doc/BRIEF.md
# Clock Output Divider with Reference Bypass

This block takes a high-rate oscillator clock, or in bypass either of two reference clocks, and produces two identical complementary output clock pairs at that source rate divided by 1, 2, 4, 8 or 16. A 3-bit ratio code picks the divide value. A level reset input holds every true output low and every complementary output high while it is asserted.

Two static selects choose the source. `pll_route_sel` high feeds the divider from the oscillator clock. Low feeds it from a reference, and `ref_diff_sel` then picks the differential-receiver reference (high) or the single-ended test reference (low). Even ratios come from a registered toggle counter. Divide-by-1 passes the source clock itself to the outputs. In both cases the duty cycle is exactly half.

A small controller clocked by the source decides when a new ratio is adopted. It has three states. `ST_HOLD` is the reset state. It is left on the first source rising edge after reset, to `ST_PASS` when the code asks for divide-by-1 and to `ST_COUNT` otherwise. `ST_COUNT` advances the counter and reloads the ratio only on the source edge that ends a divided period, which is the output's falling edge. It moves to `ST_PASS` if the new code is divide-by-1. `ST_PASS` samples the code on every source edge and moves to `ST_COUNT` when an even ratio is requested. The switch between the counter output and the pass-through clock is made on a source falling edge, so no short pulse reaches the outputs.

Top module: `outdiv_top`

## Requirements
- R1: `ratio_code` decodes as 0→÷2, 1→÷4, 2→÷8, 3→÷16, 4→÷1, 5→÷2, 6→÷4, 7→÷8 (bit 2 set selects 1,2,4,8 from bits 1:0; bit 2 clear selects 2,4,8,16).
- R2: For an even ratio R, each output period is R source periods, high for R/2 and low for R/2, and each divided period starts low.
- R3: With ratio 1 the true outputs follow the selected source clock: same period and same high time.
- R4: While `div_reset` is high, `clk0_p` and `clk1_p` are low and `clk0_n` and `clk1_n` are high. Assertion acts at once, even in the middle of a high phase.
- R5: `pll_route_sel`=1 divides `vco_clk`. `pll_route_sel`=0 divides `diff_ref_clk` when `ref_diff_sel`=1 and `test_ref_clk` when `ref_diff_sel`=0.
- R6: A ratio code change is adopted only at the end of a divided period, and no output high or low phase is ever shorter than half a source period.
- R7: After `div_reset` falls, the first output transition is a rise. For ratio R≥2 it comes R/2 source rising edges after the first source rising edge. For ratio 1 it comes on the second source rising edge.
- R8: Both pairs carry the same clock, and each `_n` output is the inverse of its `_p` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator-rate clock, the source in normal mode |
| diff_ref_clk | input | 1 | Reference from the differential receiver |
| test_ref_clk | input | 1 | Single-ended test reference |
| ref_diff_sel | input | 1 | 1: differential reference, 0: test reference |
| pll_route_sel | input | 1 | 1: oscillator clock, 0: bypass with the selected reference |
| div_reset | input | 1 | Active-high reset of the divider and outputs |
| ratio_code | input | 3 | Output divide code, decoded as in R1 |
| clk0_p | output | 1 | Pair 0 true output |
| clk0_n | output | 1 | Pair 0 complementary output |
| clk1_p | output | 1 | Pair 1 true output |
| clk1_n | output | 1 | Pair 1 complementary output |

## Verification
The bench times output edges against the selected source for all eight codes in every source route, including the non-monotonic upper half of the code table. A wrong decode shows up as a wrong period, and a wrong half-count shows up as an unequal high and low time. It changes the code in the middle of a long high phase and checks that the phase finishes at the old length. A design that reloaded at once would cut that phase short. It also crosses between pass-through and counting in both directions and requires every phase to last at least half a source period, which catches a mux switched on the wrong edge. It times the first rise after reset and asserts reset during a high phase, which catches a counter preloaded off by one and a reset that waits for a clock.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int CODE_W    = 3;
    localparam int MAX_SHIFT = 4;
    localparam int CNT_W     = MAX_SHIFT;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PASS  = 2'd2
    } div_state_t;

    // log2 of the divide ratio for a ratio code
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        logic [SHIFT_W-1:0] low;
        low = SHIFT_W'(code[1:0]);
        code_to_shift = code[2] ? low : low + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/fdiv_src_sel.sv
module fdiv_src_sel (
    input  logic vco_clk,
    input  logic diff_ref_clk,
    input  logic test_ref_clk,
    input  logic ref_diff_sel,
    input  logic pll_route_sel,
    output logic src_clk
);
    logic ref_clk;

    // selects are static while the block runs
    assign ref_clk = ref_diff_sel  ? diff_ref_clk : test_ref_clk;
    assign src_clk = pll_route_sel ? vco_clk      : ref_clk;
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
(
    input  logic                src_clk,
    input  logic                div_reset,
    input  logic [CODE_W-1:0]   ratio_code,
    output div_state_t          state,
    output logic [CNT_W-1:0]    cnt,
    output logic [SHIFT_W-1:0]  shift_act,
    output logic                half_q
);
    localparam int RW = CNT_W + 1;

    div_state_t          state_n;
    logic [CNT_W-1:0]    cnt_n;
    logic [SHIFT_W-1:0]  shift_n;
    logic [SHIFT_W-1:0]  shift_req;
    logic [RW-1:0]       ratio_cur;
    logic [RW-1:0]       ratio_nxt;
    logic                load;
    logic                q_n;

    always_comb begin
        shift_req = code_to_shift(ratio_code);
        ratio_cur = RW'(1) << shift_act;
        state_n   = state;
        cnt_n     = cnt;
        shift_n   = shift_act;
        unique case (state)
            ST_HOLD:  load = 1'b1;
            ST_COUNT: load = (({1'b0, cnt} + RW'(1)) == ratio_cur);
            ST_PASS:  load = 1'b1;
            default:  load = 1'b1;
        endcase
        if (load) begin
            shift_n = shift_req;
            cnt_n   = '0;
            state_n = (shift_req == '0) ? ST_PASS : ST_COUNT;
        end else begin
            cnt_n   = cnt + CNT_W'(1);
        end
        ratio_nxt = RW'(1) << shift_n;
        q_n       = (state_n == ST_COUNT) && ({1'b0, cnt_n} >= (ratio_nxt >> 1));
    end

    // state register
    always_ff @(posedge src_clk or posedge div_reset) begin
        if (div_reset) state <= ST_HOLD;
        else           state <= state_n;
    end

    // counter, active ratio and registered divided clock
    always_ff @(posedge src_clk or posedge div_reset) begin
        if (div_reset) begin
            cnt       <= '0;
            shift_act <= '0;
            half_q    <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            shift_act <= shift_n;
            half_q    <= q_n;
        end
    end
endmodule

// File: rtl/fdiv_out.sv
module fdiv_out #(
    parameter int PAIRS = 2
) (
    input  logic             src_clk,
    input  logic             div_reset,
    input  logic             pass_req,
    input  logic             half_q,
    output logic [PAIRS-1:0] true_o,
    output logic [PAIRS-1:0] comp_o
);
    logic pass_sel;
    logic muxed;

    // switch source on the falling edge, where both candidates are low
    always_ff @(negedge src_clk or posedge div_reset) begin
        if (div_reset) pass_sel <= 1'b0;
        else           pass_sel <= pass_req;
    end

    assign muxed = (pass_sel ? src_clk : half_q) & ~div_reset;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign true_o[g] = muxed;
        assign comp_o[g] = ~muxed;
    end
endmodule

// File: rtl/outdiv_top.sv
module outdiv_top
    import fdiv_pkg::*;
(
    input  logic              vco_clk,
    input  logic              diff_ref_clk,
    input  logic              test_ref_clk,
    input  logic              ref_diff_sel,
    input  logic              pll_route_sel,
    input  logic              div_reset,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              clk0_p,
    output logic              clk0_n,
    output logic              clk1_p,
    output logic              clk1_n
);
    localparam int OUT_PAIRS = 2;

    logic                 src_clk;
    div_state_t           state;
    logic [CNT_W-1:0]     cnt;
    logic [SHIFT_W-1:0]   shift_act;
    logic                 half_q;
    logic [OUT_PAIRS-1:0] true_v;
    logic [OUT_PAIRS-1:0] comp_v;

    fdiv_src_sel u_src (
        .vco_clk       (vco_clk),
        .diff_ref_clk  (diff_ref_clk),
        .test_ref_clk  (test_ref_clk),
        .ref_diff_sel  (ref_diff_sel),
        .pll_route_sel (pll_route_sel),
        .src_clk       (src_clk)
    );

    fdiv_ctrl u_ctrl (
        .src_clk    (src_clk),
        .div_reset  (div_reset),
        .ratio_code (ratio_code),
        .state      (state),
        .cnt        (cnt),
        .shift_act  (shift_act),
        .half_q     (half_q)
    );

    fdiv_out #(.PAIRS(OUT_PAIRS)) u_out (
        .src_clk   (src_clk),
        .div_reset (div_reset),
        .pass_req  (state == ST_PASS),
        .half_q    (half_q),
        .true_o    (true_v),
        .comp_o    (comp_v)
    );

    assign clk0_p = true_v[0];
    assign clk0_n = comp_v[0];
    assign clk1_p = true_v[1];
    assign clk1_n = comp_v[1];
endmodule

// File: rtl/outdiv_checker.sv
module outdiv_checker
    import fdiv_pkg::*;
(
    input logic               vco_clk,
    input logic               src_clk,
    input logic               div_reset,
    input div_state_t         state,
    input logic [CNT_W-1:0]   cnt,
    input logic [SHIFT_W-1:0] shift_act,
    input logic               clk0_p,
    input logic               clk0_n,
    input logic               clk1_p,
    input logic               clk1_n
);
    localparam int RW = CNT_W + 1;

    always @(posedge vco_clk) begin
        if (div_reset) begin
            assert_reset_outputs_R4: assert (!clk0_p && clk0_n && !clk1_p && clk1_n)
                else $error("reset output level wrong");
        end
    end

    assert_cnt_range_R2: assert property (@(posedge src_clk) disable iff (div_reset)
        (state == ST_COUNT) |-> ({1'b0, cnt} < (RW'(1) << shift_act)));

    assert_code_hold_R6: assert property (@(posedge src_clk) disable iff (div_reset)
        (state == ST_COUNT && (({1'b0, cnt} + RW'(1)) != (RW'(1) << shift_act)))
        |=> $stable(shift_act));

    assert_period_starts_low_R2: assert property (@(posedge src_clk) disable iff (div_reset)
        (state == ST_COUNT && cnt == '0) |-> !clk0_p);

    assert_pairs_match_R8: assert property (@(posedge src_clk) disable iff (div_reset)
        (clk1_p == clk0_p) && (clk1_n != clk1_p));
endmodule

bind outdiv_top outdiv_checker chk_i (
    .vco_clk   (vco_clk),
    .src_clk   (src_clk),
    .div_reset (div_reset),
    .state     (state),
    .cnt       (cnt),
    .shift_act (shift_act),
    .clk0_p    (clk0_p),
    .clk0_n    (clk0_n),
    .clk1_p    (clk1_p),
    .clk1_n    (clk1_n)
);

// File: tb/outdiv_top_tb_top.sv
`timescale 1ns/1ps
module outdiv_top_tb_top;
    localparam real VCO_P  = 8.0;
    localparam real DIFF_P = 20.0;
    localparam real TEST_P = 30.0;
    localparam real TOL    = 0.05;

    logic vco_clk = 1'b0;
    logic diff_ref_clk = 1'b0;
    logic test_ref_clk = 1'b0;
    logic ref_diff_sel = 1'b1;
    logic pll_route_sel = 1'b1;
    logic div_reset = 1'b1;
    logic [2:0] ratio_code = 3'd0;
    logic clk0_p, clk0_n, clk1_p, clk1_n;
    logic src_mon;

    int total = 0;
    int bad = 0;

    always #(VCO_P/2)  vco_clk = ~vco_clk;
    always #(DIFF_P/2) diff_ref_clk = ~diff_ref_clk;
    always #(TEST_P/2) test_ref_clk = ~test_ref_clk;

    // bench's own view of the selected source (R5)
    assign src_mon = pll_route_sel ? vco_clk : (ref_diff_sel ? diff_ref_clk : test_ref_clk);

    outdiv_top dut_i (
        .vco_clk(vco_clk), .diff_ref_clk(diff_ref_clk), .test_ref_clk(test_ref_clk),
        .ref_diff_sel(ref_diff_sel), .pll_route_sel(pll_route_sel), .div_reset(div_reset),
        .ratio_code(ratio_code), .clk0_p(clk0_p), .clk0_n(clk0_n), .clk1_p(clk1_p), .clk1_n(clk1_n)
    );

    task automatic chk_time(input string req, input real act, input real exp);
        total++;
        if (act < exp - TOL || act > exp + TOL) begin
            bad++;
            $display("FAIL %s: actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] c);
        int base;
        base = 1 << c[1:0];
        return c[2] ? base : 2 * base;
    endfunction

    // R4: all four outputs at reset level, sampled several times
    task automatic t_reset_levels(input string tag);
        int errs = 0;
        for (int i = 0; i < 10; i++) begin
            #3.3;
            if (clk0_p !== 1'b0 || clk1_p !== 1'b0 || clk0_n !== 1'b1 || clk1_n !== 1'b1) errs++;
        end
        chk_int({"R4 reset levels ", tag}, errs, 0);
    endtask

    // R8: pairs equal, complements inverse
    task automatic t_pairs(input string tag);
        int errs = 0;
        for (int i = 0; i < 24; i++) begin
            #2.7;
            if (clk1_p !== clk0_p || clk0_n !== ~clk0_p || clk1_n !== ~clk1_p) errs++;
        end
        chk_int({"R8 pair relation ", tag}, errs, 0);
    endtask

    // R1 R2 R3 R5 R7: start from reset and time the output
    task automatic t_run(input logic [2:0] code, input logic vsel, input logic csel,
                         input real per, input string tag);
        int r;
        real t_first, t_rise, t_fall, t_next;
        r = ratio_of(code);
        div_reset = 1'b1;
        pll_route_sel = vsel;
        ref_diff_sel = csel;
        ratio_code = code;
        #40;
        @(negedge src_mon);
        #1 div_reset = 1'b0;
        @(posedge src_mon);
        t_first = $realtime;
        @(posedge clk0_p);
        t_rise = $realtime;
        chk_time({"R7 first rise ", tag}, t_rise - t_first, (r == 1) ? per : per * (r / 2));
        @(negedge clk0_p);
        t_fall = $realtime;
        @(posedge clk0_p);
        t_next = $realtime;
        chk_time({"R1 R5 period ", tag}, t_next - t_rise, per * r);
        chk_time({(r == 1) ? "R3 high time " : "R2 high time ", tag}, t_fall - t_rise, per * r / 2.0);
        t_pairs(tag);
    endtask

    // R6: code change in the middle of a high phase, div16 -> div2
    task automatic t_change_mid_high;
        real t0, t1, t2, t3;
        t_run(3'd3, 1'b1, 1'b1, VCO_P, "div16 before change");
        @(posedge clk0_p);
        t0 = $realtime;
        #(VCO_P * 2 + 1);
        ratio_code = 3'd0;
        @(negedge clk0_p);
        t1 = $realtime;
        @(posedge clk0_p);
        t2 = $realtime;
        @(negedge clk0_p);
        t3 = $realtime;
        chk_time("R6 old high phase kept", t1 - t0, VCO_P * 8);
        chk_time("R6 new low phase", t2 - t1, VCO_P);
        chk_time("R6 new high phase", t3 - t2, VCO_P);
    endtask

    // R6: shortest phase across a change between pass-through and counting
    task automatic t_cross(input logic [2:0] from_c, input logic [2:0] to_c, input string tag);
        real last, minw;
        t_run(from_c, 1'b1, 1'b1, VCO_P, {tag, " start"});
        #5.1;
        ratio_code = to_c;
        @(clk0_p);
        last = $realtime;
        minw = 1.0e9;
        for (int i = 0; i < 10; i++) begin
            @(clk0_p);
            if ($realtime - last < minw) minw = $realtime - last;
            last = $realtime;
        end
        total++;
        if (minw < VCO_P / 2 - TOL) begin
            bad++;
            $display("FAIL R6 shortest phase %s: actual=%0.3f expected>=%0.3f", tag, minw, VCO_P / 2);
        end
    endtask

    // R4: reset asserted during a high phase acts at once and holds
    task automatic t_reset_mid_high;
        t_run(3'd3, 1'b1, 1'b1, VCO_P, "div16 before reset");
        @(posedge clk0_p);
        #(VCO_P + 0.5);
        div_reset = 1'b1;
        #0.5;
        chk_int("R4 async reset true low", int'(clk0_p), 0);
        chk_int("R4 async reset comp high", int'(clk0_n), 1);
        t_reset_levels("after mid-high reset");
    endtask

    initial begin
        #(200000 * 8.0);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_levels("power-up");
        for (int c = 0; c < 8; c++) begin
            t_run(3'(c), 1'b1, 1'b1, VCO_P, $sformatf("R1 code %0d vco", c));
        end
        t_run(3'd4, 1'b0, 1'b1, DIFF_P, "R5 bypass diff div1");
        t_run(3'd0, 1'b0, 1'b1, DIFF_P, "R5 bypass diff div2");
        t_run(3'd4, 1'b0, 1'b0, TEST_P, "R5 bypass test div1");
        t_run(3'd6, 1'b0, 1'b0, TEST_P, "R5 bypass test div4");
        t_change_mid_high();
        t_cross(3'd4, 3'd7, "div1 to div8");
        t_cross(3'd7, 3'd4, "div8 to div1");
        t_cross(3'd5, 3'd4, "div2 to div1");
        t_reset_mid_high();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule